// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Dispatcher

This block decides, once per clock, how many instructions leave a shared queue of decoded instructions and which of two in-order integer pipelines each one goes to. It looks at the two oldest queue entries. The older entry always goes to the primary pipeline. The younger entry joins it in the secondary pipeline only if three conditions hold: it is marked as able to run there, it is not a floating-point operation, and it reads no register that the older entry writes. A younger entry that is held back stays at the queue head and issues to the primary pipeline on a later cycle. Program order is never broken, and no register is renamed.

The pop count goes back to the queue in the same cycle as the decision. The issue strobes and the issued entries are registered, so each pipeline receives them one cycle later. A stall from the primary pipeline holds everything back. A flush suppresses issue in its cycle and clears the registered issue state.

Top module: `pair_dispatch`

## Requirements
- R1: While rstN is low and on the first cycle after it is released, priIssue and secIssue are 0 and priInstr and secInstr are all zeros.
- R2: An entry is 17 bits wide. Bit 16 is the secondary-capable flag and bit 15 is the floating-point flag. Bit 14 is the destination write enable and bits 13:10 are the destination register. Bit 9 is the first source valid bit and bits 8:5 are the first source register. Bit 4 is the second source valid bit and bits 3:0 are the second source register.
- R3: When oldVld is 1 and neither stall nor flush is set, the older entry issues to the primary pipeline: at the next clock edge priIssue becomes 1 and priInstr equals oldInstr.
- R4: When the older entry issues, youngVld is 1, and the younger entry is secondary-capable, not floating point and independent, the younger entry also issues: popCnt is 2, and at the next edge secIssue is 1 and secInstr equals youngInstr.
- R5: The younger entry is dependent only when the older entry's write enable is 1 and one of the younger entry's valid source fields equals the older destination. A dependent younger entry does not pair (popCnt is 1). A matching source whose valid bit is 0, or a match while the older write enable is 0, does not block pairing.
- R6: A younger entry whose secondary-capable flag is 0 never pairs.
- R7: A younger entry whose floating-point flag is 1 never pairs, even with its secondary-capable flag set. A floating-point older entry still issues to the primary pipeline and may pair with an eligible younger one.
- R8: While stall is 1, popCnt is 0, and at the next edge both issue strobes are 0 while priInstr and secInstr keep their previous values.
- R9: While flush is 1, popCnt is 0, and at the next edge both issue strobes are 0 and priInstr and secInstr are cleared to zero.
- R10: When oldVld is 0, popCnt is 0 and nothing issues, whatever youngVld holds.
- R11: popCnt is combinational and always equals the number of entries issued in the current cycle: 0, 1 or 2, never 3. When only the primary issues, secIssue is 0 at the next edge and secInstr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Suppress issue this cycle and clear issue state |
| stall | input | 1 | Primary pipeline stall; blocks all issue |
| oldVld | input | 1 | Oldest queue entry is valid |
| oldInstr | input | 17 | Oldest queue entry, fields per R2 |
| youngVld | input | 1 | Second-oldest queue entry is valid |
| youngInstr | input | 17 | Second-oldest queue entry, fields per R2 |
| popCnt | output | 2 | Entries removed from the queue this cycle |
| priIssue | output | 1 | Registered issue strobe to the primary pipeline |
| priInstr | output | 17 | Registered entry for the primary pipeline |
| secIssue | output | 1 | Registered issue strobe to the secondary pipeline |
| secInstr | output | 17 | Registered entry for the secondary pipeline |

## Verification
The only state in this block is the two registered issue slots. An error in them shows at the ports one cycle after the decision: a strobe that disagrees with the previous cycle's popCnt, a slot that holds when it should load or clear, or a secondary entry that reads the primary entry's destination. A wrong pairing decision shows in popCnt in the same cycle. The stimulus steps through every pairing condition one at a time: each source, each valid bit, the write enable and both class flags. It then checks that stall holds the slots and flush clears them, and follows with a mixed random stream.

// File: rtl/pair_dispatch_pkg.sv
package pair_dispatch_pkg;
  parameter int REG_W = 4;

  typedef struct packed {
    logic             secCap;
    logic             isFp;
    logic             dstWe;
    logic [REG_W-1:0] dst;
    logic             srcAVld;
    logic [REG_W-1:0] srcA;
    logic             srcBVld;
    logic [REG_W-1:0] srcB;
  } instrT;

  localparam int ENTRY_W = $bits(instrT);
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic issuePri;
    logic issueSec;
    logic clearAll;
  } strobeT;
endpackage

// File: rtl/pair_dispatch_dp.sv
module pair_dispatch_dp
  import pair_dispatch_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  instrT  oldIn,
  input  instrT  youngIn,
  input  strobeT strobe,
  output logic   hazard,
  output logic   priIssue,
  output instrT  priInstr,
  output logic   secIssue,
  output instrT  secInstr
);
  logic [NUM_SRC-1:0]   srcVld;
  logic [REG_W-1:0]     srcReg [NUM_SRC];
  logic [NUM_SRC-1:0]   srcHit;

  assign srcVld    = {youngIn.srcBVld, youngIn.srcAVld};
  assign srcReg[0] = youngIn.srcA;
  assign srcReg[1] = youngIn.srcB;

  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrcCmp
    assign srcHit[s] = srcVld[s] && (srcReg[s] == oldIn.dst);
  end

  assign hazard = oldIn.dstWe && (|srcHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priIssue <= 1'b0;
      secIssue <= 1'b0;
      priInstr <= '0;
      secInstr <= '0;
    end else begin
      priIssue <= strobe.issuePri;
      secIssue <= strobe.issueSec;
      if (strobe.issuePri)      priInstr <= oldIn;
      else if (strobe.clearAll) priInstr <= '0;
      if (strobe.issueSec)      secInstr <= youngIn;
      else if (strobe.clearAll) secInstr <= '0;
    end
  end
endmodule

// File: rtl/pair_dispatch_ctrl.sv
module pair_dispatch_ctrl
  import pair_dispatch_pkg::*;
(
  input  logic       oldVld,
  input  logic       youngVld,
  input  logic       youngSecCap,
  input  logic       youngIsFp,
  input  logic       hazard,
  input  logic       stall,
  input  logic       flush,
  output strobeT     strobe,
  output logic [1:0] popCnt
);
  logic canPri;
  logic canSec;

  assign canPri = oldVld && !stall && !flush;
  assign canSec = canPri && youngVld && youngSecCap && !youngIsFp && !hazard;

  always_comb begin
    strobe          = '0;
    strobe.issuePri = canPri;
    strobe.issueSec = canSec;
    strobe.clearAll = flush;
    popCnt          = {1'b0, canPri} + {1'b0, canSec};
  end
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pair_dispatch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               stall,
  input  logic               oldVld,
  input  logic [ENTRY_W-1:0] oldInstr,
  input  logic               youngVld,
  input  logic [ENTRY_W-1:0] youngInstr,
  output logic [1:0]         popCnt,
  output logic               priIssue,
  output logic [ENTRY_W-1:0] priInstr,
  output logic               secIssue,
  output logic [ENTRY_W-1:0] secInstr
);
  instrT  oldE, youngE, priE, secE;
  strobeT strobe;
  logic   hazard;

  assign oldE   = instrT'(oldInstr);
  assign youngE = instrT'(youngInstr);

  pair_dispatch_ctrl ctrl_i (
    .oldVld(oldVld), .youngVld(youngVld),
    .youngSecCap(youngE.secCap), .youngIsFp(youngE.isFp),
    .hazard(hazard), .stall(stall), .flush(flush),
    .strobe(strobe), .popCnt(popCnt)
  );

  pair_dispatch_dp dp_i (
    .clk(clk), .rstN(rstN), .oldIn(oldE), .youngIn(youngE),
    .strobe(strobe), .hazard(hazard),
    .priIssue(priIssue), .priInstr(priE),
    .secIssue(secIssue), .secInstr(secE)
  );

  assign priInstr = priE;
  assign secInstr = secE;
endmodule

// File: rtl/pair_dispatch_chk.sv
module pair_dispatch_chk
  import pair_dispatch_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               flush,
  input logic               stall,
  input logic               oldVld,
  input logic [1:0]         popCnt,
  input logic               priIssue,
  input logic [ENTRY_W-1:0] priInstr,
  input logic               secIssue,
  input logic [ENTRY_W-1:0] secInstr
);
  instrT pE, sE;
  logic  pairRaw;
  assign pE = instrT'(priInstr);
  assign sE = instrT'(secInstr);
  assign pairRaw = pE.dstWe && ((sE.srcAVld && sE.srcA == pE.dst) ||
                                (sE.srcBVld && sE.srcB == pE.dst));

  AST_SEC_NEEDS_PRI: assert property (@(posedge clk) disable iff (!rstN)
    secIssue |-> priIssue); // R4
  AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    secIssue |-> !pairRaw); // R5
  AST_NO_FP_SEC: assert property (@(posedge clk) disable iff (!rstN)
    secIssue |-> !sE.isFp); // R7
  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> popCnt == 2'd0); // R8
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!priIssue && !secIssue)); // R9
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    !oldVld |-> popCnt == 2'd0); // R10
  AST_POP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    popCnt != 2'd3); // R11
  AST_POP_TO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (popCnt != 2'd0) |=> priIssue); // R11
endmodule

bind pair_dispatch pair_dispatch_chk chk_i (
  .clk(clk), .rstN(rstN), .flush(flush), .stall(stall), .oldVld(oldVld),
  .popCnt(popCnt), .priIssue(priIssue), .priInstr(priInstr),
  .secIssue(secIssue), .secInstr(secInstr)
);

// File: tb/pair_dispatch_tb.sv
module pair_dispatch_tb_top;
  localparam int EW = 17;
  localparam int IW = 2 + 2 * EW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, stall = 1'b0, oldVld = 1'b0, youngVld = 1'b0;
  logic [EW-1:0] oldInstr = '0, youngInstr = '0;
  logic [1:0] popCnt;
  logic priIssue, secIssue;
  logic [EW-1:0] priInstr, secInstr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [IW-1:0] expQ [$];
  logic [EW-1:0] mPri = '0, mSec = '0;

  always #5 clk = ~clk;

  pair_dispatch dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .stall(stall),
    .oldVld(oldVld), .oldInstr(oldInstr), .youngVld(youngVld), .youngInstr(youngInstr),
    .popCnt(popCnt), .priIssue(priIssue), .priInstr(priInstr),
    .secIssue(secIssue), .secInstr(secInstr)
  );

  // R2 field layout
  function automatic logic [EW-1:0] mk(bit cap, bit fp, bit we, int d, bit av, int a, bit bv, int b);
    return {cap, fp, we, d[3:0], av, a[3:0], bv, b[3:0]};
  endfunction

  task automatic chk(string req, string what, logic [EW-1:0] act, logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // driver: apply one vector, check popCnt, push expected registered result
  task automatic drive(string req, bit f, bit s, bit ov, logic [EW-1:0] oi, bit yv, logic [EW-1:0] yi);
    bit pri, sec, dep;
    @(negedge clk);
    flush = f; stall = s; oldVld = ov; oldInstr = oi; youngVld = yv; youngInstr = yi;
    #1;
    dep = oi[14] && ((yi[9] && yi[8:5] == oi[13:10]) || (yi[4] && yi[3:0] == oi[13:10]));
    pri = ov && !s && !f;
    sec = pri && yv && yi[16] && !yi[15] && !dep;
    chk(req, "popCnt", EW'(popCnt), EW'(int'(pri) + int'(sec)));
    if (pri) mPri = oi; else if (f) mPri = '0;
    if (sec) mSec = yi; else if (f) mSec = '0;
    expQ.push_back({pri, mPri, sec, mSec});
  endtask

  // monitor: compare registered outputs after each edge
  always @(posedge clk) begin
    logic [IW-1:0] e;
    #1;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      chk("R3/R11", "priIssue", EW'(priIssue), EW'(e[IW-1]));
      chk("R3", "priInstr", priInstr, e[IW-2 -: EW]);
      chk("R4/R11", "secIssue", EW'(secIssue), EW'(e[EW]));
      chk("R4", "secInstr", secInstr, e[EW-1:0]);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [EW-1:0] o1;
    o1 = mk(0, 0, 1, 5, 1, 2, 1, 3);
    @(negedge clk);
    oldVld = 1'b1; oldInstr = o1; youngVld = 1'b1; youngInstr = mk(1,0,0,0,0,0,0,0);
    repeat (3) @(negedge clk);
    chk("R1", "priIssue in reset", EW'(priIssue), '0);
    chk("R1", "secInstr in reset", secInstr, '0);
    rstN = 1'b1;
    #1;
    chk("R1", "secIssue before edge", EW'(secIssue), '0);
    // R4 independent pair
    drive("R4", 0, 0, 1, o1, 1, mk(1, 0, 1, 7, 1, 1, 1, 2));
    // R5 dependence through each source
    drive("R5", 0, 0, 1, o1, 1, mk(1, 0, 1, 7, 1, 5, 1, 2));
    drive("R5", 0, 0, 1, o1, 1, mk(1, 0, 0, 0, 0, 0, 1, 5));
    // R5 match with invalid source, and with no write enable
    drive("R5", 0, 0, 1, o1, 1, mk(1, 0, 0, 0, 0, 5, 1, 6));
    drive("R5", 0, 0, 1, mk(0, 0, 0, 5, 0, 0, 0, 0), 1, mk(1, 0, 0, 0, 1, 5, 1, 5));
    // R6 not secondary-capable
    drive("R6", 0, 0, 1, o1, 1, mk(0, 0, 1, 9, 1, 1, 0, 0));
    // R7 FP younger never pairs; FP older pairs
    drive("R7", 0, 0, 1, o1, 1, mk(1, 1, 1, 9, 1, 1, 0, 0));
    drive("R7", 0, 0, 1, mk(0, 1, 1, 4, 0, 0, 0, 0), 1, mk(1, 0, 1, 8, 1, 1, 1, 2));
    // R8 stall holds slots
    drive("R8", 0, 1, 1, o1, 1, mk(1, 0, 1, 7, 1, 1, 1, 2));
    drive("R8", 0, 1, 1, o1, 0, '0);
    // R9 flush clears
    drive("R4", 0, 0, 1, o1, 1, mk(1, 0, 1, 7, 1, 1, 1, 2));
    drive("R9", 1, 0, 1, o1, 1, mk(1, 0, 1, 7, 1, 1, 1, 2));
    // R10 empty head with younger valid
    drive("R10", 0, 0, 0, o1, 1, mk(1, 0, 1, 7, 1, 1, 1, 2));
    // R11 primary only: sec slot holds
    drive("R4", 0, 0, 1, o1, 1, mk(1, 0, 1, 7, 1, 1, 1, 2));
    drive("R11", 0, 0, 1, o1, 0, mk(1, 0, 1, 3, 0, 0, 0, 0));
    // mixed stream
    for (int i = 0; i < 200; i++) begin
      logic [EW-1:0] a, b;
      a = EW'($urandom);
      b = EW'($urandom);
      drive("R11", ($urandom % 10) == 0, ($urandom % 8) == 0, ($urandom % 6) != 0, a,
            ($urandom % 5) != 0, b);
    end
    @(negedge clk);
    flush = 1'b0; stall = 1'b0; oldVld = 1'b0; youngVld = 1'b0;
    @(posedge clk); #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule